// File: doc/BRIEF.md
# Port Activity LED Status Formatter

This block prepares the per-port portion of a serial LED status chain for up to eight network ports. For every port it produces a short, right-aligned bit field together with the number of valid bits in it. A downstream serializer shifts each field out starting at field bit 0. The field mixes stretched transmit and receive activity with a slice of a 6-bit software status word, and a 4-bit format code selects the mix.

Raw activity pulses are often a single cycle long, so each port has one stretcher for transmit and one for receive. A stretcher lights on any pulse and goes dark only at a blink boundary. A blink boundary comes once every `blink_rate` frame-latch ticks. Ports that are masked off emit nothing. The block also reports where each enabled port's field starts in the chain, with enabled ports packed from the lowest port number up, and the total bit count.

Top module: `led_port_status`

## Requirements
- R1: Format codes 0x0, 0x1, 0x2 and 0x3 give a field of the status slice alone: status[0] (count 1), status[1:0] (count 2), status[3:0] (count 4) or status[5:0] (count 6). Status bit k sits at field bit k, and field bit 0 is emitted first.
- R2: Codes 0x4, 0x5 and 0x6 put the combined activity bit (stretched TX OR stretched RX) at field bit 0. The status slice status[0], status[1:0] or status[3:0] follows from field bit 1, giving counts 2, 3 and 5.
- R3: Codes 0x8, 0x9 and 0xA put stretched TX at field bit 0 and stretched RX at field bit 1. The status slice status[0], status[1:0] or status[3:0] follows from field bit 2, giving counts 3, 4 and 6.
- R4: Codes 0x7 and 0xB through 0xF give a count of 0 and an all-zero field for every port.
- R5: A port whose bit in `port_en` is 0 has a count of 0 and an all-zero field. In every field, the bits at and above the count are zero, so status bits outside the selected slice have no effect.
- R6: An enabled port's start offset equals the sum of the counts of all lower-numbered ports. `total_bits` equals the sum of all counts.
- R7: A high pulse on `tx_act[p]` or `rx_act[p]` in one cycle turns that port's stretched indication on from the next cycle.
- R8: A stretched indication goes off only at a blink boundary, and only if no pulse arrived since the previous boundary. A pulse in the same cycle as a boundary keeps the indication on and counts toward the period that starts there.
- R9: A blink boundary falls on every `blink_rate`-th `latch_tick` counted from reset. A rate of 0 is treated as 1.
- R10: After reset all stretched indications are off and the tick count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_act | input | NUM_PORTS | Raw transmit activity, one bit per port |
| rx_act | input | NUM_PORTS | Raw receive activity, one bit per port |
| sw_status | input | NUM_PORTS*6 | Software status words, port p at bits [6p+5:6p] |
| port_en | input | NUM_PORTS | Per-port output enable mask |
| fmt_code | input | 4 | Field format selector |
| blink_rate | input | RATE_W | Latch ticks per blink period |
| latch_tick | input | 1 | One-cycle frame-latch tick |
| field_bits | output | NUM_PORTS*6 | Per-port field, port p at bits [6p+5:6p] |
| field_cnt | output | NUM_PORTS*3 | Per-port valid bit count, port p at bits [3p+2:3p] |
| field_ofs | output | NUM_PORTS*OFS_W | Per-port start offset in the chain |
| total_bits | output | OFS_W | Sum of all counts |

## Verification
The main coincidence is an activity pulse that lands in the same cycle as a blink boundary. The stretcher then has to choose between clearing and holding. The bench drives `latch_tick` itself and counts ticks from reset, so it knows which tick is a boundary. It places a pulse exactly on such a tick for an indication that would otherwise go dark there. It then checks that the indication stays lit through the next full period and goes dark only one boundary later. A pulse on another port at the same boundary where the first indication clears must light that port without affecting the first.

// File: rtl/led_fmt_pkg.sv
package led_fmt_pkg;
  localparam int FIELD_W = 6;
  localparam int CNT_W   = 3;

  typedef struct packed {
    logic [FIELD_W-1:0] bits;
    logic [CNT_W-1:0]   cnt;
  } field_t;

  // status slice length selected by the low two code bits
  function automatic logic [CNT_W-1:0] slice_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  // legal codes: no-prefix group any slice; prefix groups not the 6-bit slice
  function automatic logic code_legal(input logic [3:0] code);
    return (code[3:2] == 2'd0) || ((code[3:2] != 2'd3) && (code[1:0] != 2'd3));
  endfunction

  function automatic field_t format_field(input logic [3:0] code, input logic tx,
                                          input logic rx, input logic [FIELD_W-1:0] stat);
    field_t           f;
    logic [FIELD_W:0] mask;
    logic [1:0]       pre;
    logic [FIELD_W-1:0] lead;
    logic [CNT_W-1:0] n;
    n    = slice_len(code[1:0]);
    mask = (7'd1 << n) - 7'd1;
    pre  = code[3:2];
    lead = '0;
    if (pre == 2'd1) lead[0] = tx | rx;
    if (pre == 2'd2) begin
      lead[0] = tx;
      lead[1] = rx;
    end
    if (!code_legal(code)) begin
      f.bits = '0;
      f.cnt  = '0;
    end else begin
      f.bits = ((stat & mask[FIELD_W-1:0]) << pre) | lead;
      f.cnt  = n + {1'b0, pre};
    end
    return f;
  endfunction
endpackage

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              boundary
);
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] lim;

  assign lim      = (rate == '0) ? RATE_W'(1) : rate;
  assign boundary = tick && (cnt_q >= lim - RATE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (boundary) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + RATE_W'(1);
  end
endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  input  logic boundary,
  output logic lit
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit    <= 1'b0;
      seen_q <= 1'b0;
    end else if (boundary) begin
      lit    <= seen_q | pulse;
      seen_q <= pulse;
    end else if (pulse) begin
      lit    <= 1'b1;
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/led_field_pack.sv
module led_field_pack
  import led_fmt_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int OFS_W     = 6
) (
  input  logic [3:0]                 code,
  input  logic [NUM_PORTS-1:0]       en,
  input  logic [NUM_PORTS-1:0]       tx_lit,
  input  logic [NUM_PORTS-1:0]       rx_lit,
  input  logic [NUM_PORTS*FIELD_W-1:0] stat,
  output logic [NUM_PORTS*FIELD_W-1:0] bits,
  output logic [NUM_PORTS*CNT_W-1:0] cnt,
  output logic [NUM_PORTS*OFS_W-1:0] ofs,
  output logic [OFS_W-1:0]           total
);
  field_t fld [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      fld[p] = format_field(code, tx_lit[p], rx_lit[p], stat[p*FIELD_W +: FIELD_W]);
      if (!en[p]) fld[p] = '0;
    end
    assign bits[p*FIELD_W +: FIELD_W] = fld[p].bits;
    assign cnt[p*CNT_W +: CNT_W]      = fld[p].cnt;
  end

  always_comb begin
    logic [OFS_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      ofs[p*OFS_W +: OFS_W] = acc;
      acc = acc + OFS_W'(fld[p].cnt);
    end
    total = acc;
  end
endmodule

// File: rtl/led_port_status.sv
module led_port_status
  import led_fmt_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int RATE_W    = 8,
  localparam int OFS_W    = $clog2(NUM_PORTS * FIELD_W + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PORTS-1:0]         tx_act,
  input  logic [NUM_PORTS-1:0]         rx_act,
  input  logic [NUM_PORTS*FIELD_W-1:0] sw_status,
  input  logic [NUM_PORTS-1:0]         port_en,
  input  logic [3:0]                   fmt_code,
  input  logic [RATE_W-1:0]            blink_rate,
  input  logic                         latch_tick,
  output logic [NUM_PORTS*FIELD_W-1:0] field_bits,
  output logic [NUM_PORTS*CNT_W-1:0]   field_cnt,
  output logic [NUM_PORTS*OFS_W-1:0]   field_ofs,
  output logic [OFS_W-1:0]             total_bits
);
  logic                 blink_edge;
  logic [NUM_PORTS-1:0] tx_lit;
  logic [NUM_PORTS-1:0] rx_lit;

  led_blink_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(latch_tick), .rate(blink_rate), .boundary(blink_edge)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_str
    led_act_stretch u_tx (
      .clk(clk), .rst_n(rst_n), .pulse(tx_act[p]), .boundary(blink_edge), .lit(tx_lit[p])
    );
    led_act_stretch u_rx (
      .clk(clk), .rst_n(rst_n), .pulse(rx_act[p]), .boundary(blink_edge), .lit(rx_lit[p])
    );
  end

  led_field_pack #(.NUM_PORTS(NUM_PORTS), .OFS_W(OFS_W)) u_pack (
    .code(fmt_code), .en(port_en), .tx_lit(tx_lit), .rx_lit(rx_lit), .stat(sw_status),
    .bits(field_bits), .cnt(field_cnt), .ofs(field_ofs), .total(total_bits)
  );
endmodule

// File: rtl/led_port_status_chk.sv
module led_port_status_chk #(
  parameter int NUM_PORTS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_PORTS-1:0]   tx_act,
  input logic [NUM_PORTS-1:0]   rx_act,
  input logic                   latch_tick,
  input logic [NUM_PORTS-1:0]   port_en,
  input logic                   blink_edge,
  input logic [NUM_PORTS-1:0]   tx_lit,
  input logic [NUM_PORTS-1:0]   rx_lit,
  input logic [NUM_PORTS*6-1:0] field_bits,
  input logic [NUM_PORTS*3-1:0] field_cnt
);
  // R9
  boundary_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blink_edge |-> latch_tick);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R7
    tx_pulse_lights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_act[p] |=> tx_lit[p]);
    // R7
    rx_pulse_lights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_act[p] |=> rx_lit[p]);
    // R8
    tx_clear_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_lit[p]) |-> $past(blink_edge));
    // R8
    rx_clear_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_lit[p]) |-> $past(blink_edge));
    // R5
    masked_port_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en[p] |-> (field_cnt[p*3 +: 3] == 3'd0 && field_bits[p*6 +: 6] == 6'd0));
    // R1
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_cnt[p*3 +: 3] <= 3'd6);
  end
endmodule

bind led_port_status led_port_status_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act), .latch_tick(latch_tick),
  .port_en(port_en), .blink_edge(blink_edge), .tx_lit(tx_lit), .rx_lit(rx_lit),
  .field_bits(field_bits), .field_cnt(field_cnt)
);

// File: tb/led_port_status_tb.sv
module led_port_status_tb;
  localparam int NP = 8;
  localparam int OW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   tx_act = '0, rx_act = '0, port_en = '1;
  logic [NP*6-1:0] sw_status = '0;
  logic [3:0]      fmt_code = 4'h8;
  logic [7:0]      blink_rate = 8'd3;
  logic            latch_tick = 1'b0;
  logic [NP*6-1:0] field_bits;
  logic [NP*3-1:0] field_cnt;
  logic [NP*OW-1:0] field_ofs;
  logic [OW-1:0]   total_bits;

  int vectors = 0, errors = 0, ticks = 0;

  always #4 clk = ~clk;

  led_port_status u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // expected field per the requirement tables
  task automatic exp_field(input int code, input bit t, input bit r, input bit [5:0] s,
                           output int b, output int c);
    case (code)
      0:  begin b = s[0];               c = 1; end
      1:  begin b = s[1:0];             c = 2; end
      2:  begin b = s[3:0];             c = 4; end
      3:  begin b = s;                  c = 6; end
      4:  begin b = {s[0], t | r};      c = 2; end
      5:  begin b = {s[1:0], t | r};    c = 3; end
      6:  begin b = {s[3:0], t | r};    c = 5; end
      8:  begin b = {s[0], r, t};       c = 3; end
      9:  begin b = {s[1:0], r, t};     c = 4; end
      10: begin b = {s[3:0], r, t};     c = 6; end
      default: begin b = 0; c = 0; end
    endcase
  endtask

  // drive one cycle from a negedge, return at the next negedge
  task automatic step(input logic [NP-1:0] t, input logic [NP-1:0] r, input logic tk);
    tx_act = t; rx_act = r; latch_tick = tk;
    @(negedge clk);
    tx_act = '0; rx_act = '0; latch_tick = 1'b0;
    if (tk) ticks++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ticks = 0;
    @(negedge clk);
  endtask

  // with code 0x8 and zero status the field reads {rx, tx}
  task automatic chk_act(input string req, input int p, input bit t, input bit r);
    check(req, int'(field_bits[p*6 +: 6]), {r, t});
  endtask

  task automatic test_reset();
    fmt_code = 4'h8; sw_status = '0; port_en = '1;
    do_reset();
    for (int p = 0; p < NP; p++) begin
      chk_act("R10 indications off", p, 1'b0, 1'b0);
      check("R10 count", int'(field_cnt[p*3 +: 3]), 3);
    end
  endtask

  task automatic sweep_codes(input logic [NP-1:0] tl, input logic [NP-1:0] rl);
    int b, c, off;
    for (int code = 0; code < 16; code++) begin
      string tag;
      fmt_code = 4'(code);
      #1;
      tag = (code < 4) ? "R1 slice" : (code < 7) ? "R2 combined" :
            (code >= 8 && code <= 10) ? "R3 tx rx" : "R4 illegal code";
      off = 0;
      for (int p = 0; p < NP; p++) begin
        exp_field(code, tl[p], rl[p], sw_status[p*6 +: 6], b, c);
        check(tag, int'(field_bits[p*6 +: 6]), b);
        check(tag, int'(field_cnt[p*3 +: 3]), c);
        check("R6 offset", int'(field_ofs[p*OW +: OW]), off);
        off += c;
      end
      check("R6 total", int'(total_bits), off);
    end
  endtask

  task automatic test_formats();
    port_en = '1;
    for (int p = 0; p < NP; p++) sw_status[p*6 +: 6] = 6'(p * 11 + 5);
    do_reset();
    sweep_codes('0, '0);
    step(8'b0101_0101, 8'b0000_0110, 1'b0);
    sweep_codes(8'b0101_0101, 8'b0000_0110);
  endtask

  task automatic test_enable();
    fmt_code = 4'h2;
    port_en = 8'b1010_0110;
    sw_status = {NP{6'h3f}};
    #1;
    for (int p = 0; p < NP; p++) begin
      if (!port_en[p]) begin
        check("R5 masked cnt", int'(field_cnt[p*3 +: 3]), 0);
        check("R5 masked bits", int'(field_bits[p*6 +: 6]), 0);
      end else begin
        check("R5 upper bits zero", int'(field_bits[p*6 +: 6]), 15);
      end
    end
    check("R6 offset p1", int'(field_ofs[1*OW +: OW]), 0);
    check("R6 offset p2", int'(field_ofs[2*OW +: OW]), 4);
    check("R6 offset p5", int'(field_ofs[5*OW +: OW]), 8);
    check("R6 offset p7", int'(field_ofs[7*OW +: OW]), 12);
    check("R6 total", int'(total_bits), 16);
    port_en = '1;
  endtask

  // rate 3: boundaries on ticks 3, 6, 9, 12, 15, 18
  task automatic test_stretch();
    fmt_code = 4'h8; sw_status = '0; port_en = '1; blink_rate = 8'd3;
    do_reset();
    step(8'h01, 8'h00, 1'b0);
    chk_act("R7 tx lit next cycle", 0, 1'b1, 1'b0);
    chk_act("R7 rx untouched", 1, 1'b0, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      step('0, '0, 1'b1);
      chk_act("R9 no clear before second boundary", 0, 1'b1, 1'b0);
    end
    step(8'h01, 8'h00, 1'b1);      // tick 6: pulse on a boundary
    chk_act("R8 pulse on boundary holds", 0, 1'b1, 1'b0);
    for (int k = 7; k <= 11; k++) begin
      step('0, '0, 1'b1);
      chk_act("R8 held after boundary pulse", 0, 1'b1, 1'b0);
    end
    step(8'h00, 8'h02, 1'b1);      // tick 12: port 0 clears, port 1 rx lights
    chk_act("R8 clears on quiet boundary", 0, 1'b0, 1'b0);
    chk_act("R7 rx lit on boundary pulse", 1, 1'b0, 1'b1);
    for (int k = 13; k <= 17; k++) begin
      step('0, '0, 1'b1);
      chk_act("R8 rx held", 1, 1'b0, 1'b1);
    end
    step('0, '0, 1'b1);            // tick 18
    chk_act("R8 rx clears", 1, 1'b0, 1'b0);
    step('0, '0, 1'b0);
    chk_act("R8 stays dark", 1, 1'b0, 1'b0);
  endtask

  task automatic test_rate_zero();
    fmt_code = 4'h8; sw_status = '0; blink_rate = 8'd0;
    do_reset();
    step(8'h04, 8'h00, 1'b0);
    chk_act("R9 rate0 lit", 2, 1'b1, 1'b0);
    step('0, '0, 1'b1);
    chk_act("R9 rate0 first boundary holds", 2, 1'b1, 1'b0);
    step('0, '0, 1'b1);
    chk_act("R9 rate0 second boundary clears", 2, 1'b0, 1'b0);
    blink_rate = 8'd3;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_formats();
    test_enable();
    test_stretch();
    test_rate_zero();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule